// File: doc/BRIEF.md
# Tagged Parameter Distribution Chain

This block loads runtime settings into user logic at start-up. A host channel
delivers a stream of fixed-width words. A central framing stage decides for each
word whether it is a header, a value word or the end marker. It then passes the
word down a chain of receiver nodes. Each user module owns one node. A node holds
a small bank of parameter registers and keeps only the value words addressed to
its own module ID. Because the values come from the host at launch, they can
change without rebuilding the hardware.

Every word moves one chain stage per cycle under valid/ready handshaking. The
words leave the last node unchanged, so a second chain can be cascaded behind
this one. When the end marker has passed a node, that node raises a sticky
`params_valid` flag. User logic waits for this flag before it reads the
parameter registers.

Top module: `param_dist`

## Requirements
- R1: After reset every parameter register holds `PARAM_DEFAULT`. Every `params_valid_o` bit and every `param_err_o` bit is 0.
- R2: A header word carries the module ID in bits [31:24], the starting register index in bits [23:16] and the number of value words in bits [15:0]. The node whose ID equals `BASE_ID + n` (node n) writes the value words that follow into registers index, index+1 and onward.
- R3: A node whose ID differs from the header ID leaves all of its registers unchanged.
- R4: A value word aimed at a register index of `NUM_REGS` or more is dropped. The `param_err_o` bit of the target node then sets and stays set until reset. Other nodes' error bits stay clear.
- R5: A word whose ID field is 8'hFF at a header position is the end marker. After it passes, every `params_valid_o` bit is set and stays set. Before it passes, no bit is set.
- R6: Each word entering `in_data_i` appears on `tail_data_o` unchanged and in order. Its latency is `NUM_NODES + 1` cycles when the tail is not stalled.
- R7: While `tail_ready_i` is low, `tail_valid_o` and `tail_data_o` hold. The chain accepts at most `NUM_NODES + 1` words and then drops `in_ready_o`. No word is lost or duplicated.
- R8: A header with a length of 0 writes nothing. The next word is taken as a header.
- R9: A later write to the same register replaces its earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Host word valid |
| in_data_i | input | WORD_W | Host word |
| in_ready_o | output | 1 | Chain accepts a host word |
| tail_valid_o | output | 1 | Forwarded word valid at chain end |
| tail_data_o | output | WORD_W | Forwarded word |
| tail_ready_i | input | 1 | Downstream accepts forwarded word |
| params_valid_o | output | NUM_NODES | Per-node sticky "parameters loaded" flag |
| param_err_o | output | NUM_NODES | Per-node sticky out-of-range index flag |
| param_vals_o | output | NUM_NODES*NUM_REGS*WORD_W | All parameter registers, node n register r at slice (n*NUM_REGS+r)*WORD_W |

## Verification
The stream patterns are multi-word bursts, zero-length headers and repeated writes to one register. These separate correct index stepping and header re-framing from off-by-one and stale-pointer faults. Headers for unknown IDs and for the other nodes show that only the addressed node changes. A burst that runs past the last register checks both the drop and the error flag on that one node. A stalled tail fills the chain, which exposes lost or duplicated words and a wrong `in_ready_o` capacity. The end marker is sent last, so an early or non-sticky `params_valid_o` shows.

// File: rtl/param_dist_pkg.sv
package param_dist_pkg;
  localparam int ID_W    = 8;
  localparam int IDX_W   = 8;
  localparam int LEN_W   = 16;
  localparam int ID_LSB  = 24;
  localparam int IDX_LSB = 16;
  localparam logic [ID_W-1:0] END_ID = 8'hFF;

  typedef enum logic [1:0] {
    BK_HDR = 2'd0,
    BK_VAL = 2'd1,
    BK_END = 2'd2
  } beat_kind_e;
endpackage

// File: rtl/param_ctrl.sv
module param_ctrl
  import param_dist_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output beat_kind_e        out_kind_o,
  output logic [WORD_W-1:0] out_data_o,
  input  logic              out_ready_i
);
  logic              valid_q;
  beat_kind_e        kind_q;
  logic [WORD_W-1:0] data_q;
  logic [LEN_W-1:0]  remain_q;
  logic              accept;

  assign in_ready_o  = !valid_q || out_ready_i;
  assign accept      = in_valid_i && in_ready_o;
  assign out_valid_o = valid_q;
  assign out_kind_o  = kind_q;
  assign out_data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      kind_q   <= BK_HDR;
      data_q   <= '0;
      remain_q <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      data_q  <= in_data_i;
      if (remain_q == '0) begin
        if (in_data_i[ID_LSB +: ID_W] == END_ID) begin
          kind_q <= BK_END;
        end else begin
          kind_q   <= BK_HDR;
          remain_q <= in_data_i[LEN_W-1:0];
        end
      end else begin
        kind_q   <= BK_VAL;
        remain_q <= remain_q - 1'b1;
      end
    end else if (out_ready_i) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/param_node.sv
module param_node
  import param_dist_pkg::*;
#(
  parameter int              WORD_W   = 32,
  parameter int              NUM_REGS = 4,
  parameter logic [ID_W-1:0] NODE_ID  = 8'h01,
  parameter logic [WORD_W-1:0] PARAM_DEFAULT = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       up_valid_i,
  input  beat_kind_e                 up_kind_i,
  input  logic [WORD_W-1:0]          up_data_i,
  output logic                       up_ready_o,
  output logic                       dn_valid_o,
  output beat_kind_e                 dn_kind_o,
  output logic [WORD_W-1:0]          dn_data_o,
  input  logic                       dn_ready_i,
  output logic [NUM_REGS*WORD_W-1:0] regs_o,
  output logic                       params_valid_o,
  output logic                       err_o
);
  localparam int PTR_W = IDX_W + 1;
  localparam logic [PTR_W-1:0] REG_LIMIT = PTR_W'(NUM_REGS);

  logic              valid_q;
  beat_kind_e        kind_q;
  logic [WORD_W-1:0] data_q;
  logic              match_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              loaded_q;
  logic              err_q;
  logic              accept;
  logic              val_hit;
  logic              wr_en;

  assign up_ready_o     = !valid_q || dn_ready_i;
  assign accept         = up_valid_i && up_ready_o;
  assign dn_valid_o     = valid_q;
  assign dn_kind_o      = kind_q;
  assign dn_data_o      = data_q;
  assign params_valid_o = loaded_q;
  assign err_o          = err_q;

  assign val_hit = accept && (up_kind_i == BK_VAL) && match_q;
  assign wr_en   = val_hit && (ptr_q < REG_LIMIT);

  // forwarding stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      kind_q  <= BK_HDR;
      data_q  <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      kind_q  <= up_kind_i;
      data_q  <= up_data_i;
    end else if (dn_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  // framing state of this node
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q  <= 1'b0;
      ptr_q    <= '0;
      loaded_q <= 1'b0;
      err_q    <= 1'b0;
    end else if (accept) begin
      unique case (up_kind_i)
        BK_HDR: begin
          match_q <= (up_data_i[ID_LSB +: ID_W] == NODE_ID);
          ptr_q   <= {1'b0, up_data_i[IDX_LSB +: IDX_W]};
        end
        BK_VAL: begin
          if (ptr_q != '1) ptr_q <= ptr_q + 1'b1;
          if (val_hit && !wr_en) err_q <= 1'b1;
        end
        BK_END: begin
          loaded_q <= 1'b1;
          match_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [WORD_W-1:0] reg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        reg_q <= PARAM_DEFAULT;
      else if (wr_en && (ptr_q == PTR_W'(r)))
        reg_q <= up_data_i;
    end
    assign regs_o[r*WORD_W +: WORD_W] = reg_q;
  end
endmodule

// File: rtl/param_dist.sv
module param_dist
  import param_dist_pkg::*;
#(
  parameter int NUM_NODES = 3,
  parameter int NUM_REGS  = 4,
  parameter int WORD_W    = 32,
  parameter int BASE_ID   = 1,
  parameter logic [WORD_W-1:0] PARAM_DEFAULT = WORD_W'(32'h5A5A_5A5A)
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  in_valid_i,
  input  logic [WORD_W-1:0]                     in_data_i,
  output logic                                  in_ready_o,
  output logic                                  tail_valid_o,
  output logic [WORD_W-1:0]                     tail_data_o,
  input  logic                                  tail_ready_i,
  output logic [NUM_NODES-1:0]                  params_valid_o,
  output logic [NUM_NODES-1:0]                  param_err_o,
  output logic [NUM_NODES*NUM_REGS*WORD_W-1:0]  param_vals_o
);
  localparam int BANK_W = NUM_REGS * WORD_W;

  logic              ch_valid [NUM_NODES+1];
  beat_kind_e        ch_kind  [NUM_NODES+1];
  logic [WORD_W-1:0] ch_data  [NUM_NODES+1];
  logic              ch_ready [NUM_NODES+1];

  param_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (ch_valid[0]),
    .out_kind_o  (ch_kind[0]),
    .out_data_o  (ch_data[0]),
    .out_ready_i (ch_ready[0])
  );

  for (genvar n = 0; n < NUM_NODES; n++) begin : g_node
    param_node #(
      .WORD_W        (WORD_W),
      .NUM_REGS      (NUM_REGS),
      .NODE_ID       (ID_W'(BASE_ID + n)),
      .PARAM_DEFAULT (PARAM_DEFAULT)
    ) u_node (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .up_valid_i     (ch_valid[n]),
      .up_kind_i      (ch_kind[n]),
      .up_data_i      (ch_data[n]),
      .up_ready_o     (ch_ready[n]),
      .dn_valid_o     (ch_valid[n+1]),
      .dn_kind_o      (ch_kind[n+1]),
      .dn_data_o      (ch_data[n+1]),
      .dn_ready_i     (ch_ready[n+1]),
      .regs_o         (param_vals_o[n*BANK_W +: BANK_W]),
      .params_valid_o (params_valid_o[n]),
      .err_o          (param_err_o[n])
    );
  end

  assign ch_ready[NUM_NODES] = tail_ready_i;
  assign tail_valid_o        = ch_valid[NUM_NODES];
  assign tail_data_o         = ch_data[NUM_NODES];
endmodule

// File: rtl/param_dist_chk.sv
module param_dist_chk #(
  parameter int NUM_NODES = 3,
  parameter int WORD_W    = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 in_ready_o,
  input logic                 tail_valid_o,
  input logic [WORD_W-1:0]    tail_data_o,
  input logic                 tail_ready_i,
  input logic [NUM_NODES-1:0] params_valid_o,
  input logic [NUM_NODES-1:0] param_err_o
);
  a_r7_tail_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tail_valid_o && !tail_ready_i) |=> (tail_valid_o && $stable(tail_data_o)));

  a_r7_free_tail_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tail_valid_o |-> in_ready_o);

  for (genvar n = 0; n < NUM_NODES; n++) begin : g_n
    a_r5_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      params_valid_o[n] |=> params_valid_o[n]);
    a_r4_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      param_err_o[n] |=> param_err_o[n]);
    if (n > 0) begin : g_ord
      // end marker reaches nodes in chain order
      a_r5_valid_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(params_valid_o[n]) |-> params_valid_o[n-1]);
    end
  end
endmodule

bind param_dist param_dist_chk #(
  .NUM_NODES (NUM_NODES),
  .WORD_W    (WORD_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .in_ready_o     (in_ready_o),
  .tail_valid_o   (tail_valid_o),
  .tail_data_o    (tail_data_o),
  .tail_ready_i   (tail_ready_i),
  .params_valid_o (params_valid_o),
  .param_err_o    (param_err_o)
);

// File: tb/param_dist_tb_top.sv
`timescale 1ns/1ps
module param_dist_tb_top;
  localparam int NN  = 3;
  localparam int NR  = 4;
  localparam int W   = 32;
  localparam logic [31:0] DEF = 32'h5A5A_5A5A;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            in_valid_i = 1'b0;
  logic [W-1:0]    in_data_i = '0;
  logic            in_ready_o;
  logic            tail_valid_o;
  logic [W-1:0]    tail_data_o;
  logic            tail_ready_i = 1'b1;
  logic [NN-1:0]   params_valid_o;
  logic [NN-1:0]   param_err_o;
  logic [NN*NR*W-1:0] param_vals_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [W-1:0] sent_log [256];
  logic [W-1:0] tail_log [256];
  int n_sent = 0;
  int n_tail = 0;

  always #2.5 clk_i = ~clk_i;

  param_dist #(.NUM_NODES(NN), .NUM_REGS(NR), .WORD_W(W), .BASE_ID(1),
               .PARAM_DEFAULT(DEF)) dut_i (.*);

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (rst_ni && tail_valid_o && tail_ready_i && n_tail < 256) begin
      tail_log[n_tail] <= tail_data_o;
      n_tail <= n_tail + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] hdr(input logic [7:0] id, input logic [7:0] idx,
                                       input logic [15:0] len);
    return {id, idx, len};
  endfunction

  function automatic logic [W-1:0] reg_of(input int n, input int r);
    return param_vals_o[(n*NR+r)*W +: W];
  endfunction

  task automatic send(input logic [W-1:0] w);
    @(negedge clk_i);
    while (!in_ready_o) begin
      in_valid_i = 1'b0;
      @(negedge clk_i);
    end
    in_valid_i = 1'b1;
    in_data_i  = w;
    if (n_sent < 256) sent_log[n_sent] = w;
    n_sent++;
  endtask

  task automatic settle();
    @(negedge clk_i);
    in_valid_i = 1'b0;
    repeat (NN + 3) @(negedge clk_i);
  endtask

  task automatic t_reset();
    for (int n = 0; n < NN; n++)
      for (int r = 0; r < NR; r++)
        chk(reg_of(n, r) == DEF, "R1 reset value", reg_of(n, r), DEF);
    chk(params_valid_o == '0, "R1 params_valid low", W'(params_valid_o), '0);
    chk(param_err_o == '0, "R1 err low", W'(param_err_o), '0);
  endtask

  task automatic t_burst();
    send(hdr(8'd2, 8'd1, 16'd2));
    send(32'h1111_0001);
    send(32'h2222_0002);
    settle();
    chk(reg_of(1, 1) == 32'h1111_0001, "R2 burst word0", reg_of(1, 1), 32'h1111_0001);
    chk(reg_of(1, 2) == 32'h2222_0002, "R2 burst word1", reg_of(1, 2), 32'h2222_0002);
    chk(reg_of(1, 0) == DEF, "R3 untouched index", reg_of(1, 0), DEF);
    for (int r = 0; r < NR; r++) begin
      chk(reg_of(0, r) == DEF, "R3 other node0", reg_of(0, r), DEF);
      chk(reg_of(2, r) == DEF, "R3 other node2", reg_of(2, r), DEF);
    end
    chk(params_valid_o == '0, "R5 not before end", W'(params_valid_o), '0);
  endtask

  task automatic t_zero_len();
    send(hdr(8'd1, 8'd0, 16'd0));
    send(hdr(8'd1, 8'd3, 16'd1));
    send(32'hC0C0_0003);
    settle();
    chk(reg_of(0, 0) == DEF, "R8 zero length no write", reg_of(0, 0), DEF);
    chk(reg_of(0, 3) == 32'hC0C0_0003, "R8 next word is header", reg_of(0, 3), 32'hC0C0_0003);
  endtask

  task automatic t_overwrite();
    send(hdr(8'd2, 8'd1, 16'd1));
    send(32'hD00D_0004);
    settle();
    chk(reg_of(1, 1) == 32'hD00D_0004, "R9 overwrite", reg_of(1, 1), 32'hD00D_0004);
    chk(reg_of(1, 2) == 32'h2222_0002, "R9 neighbour kept", reg_of(1, 2), 32'h2222_0002);
  endtask

  task automatic t_out_of_range();
    send(hdr(8'd3, 8'd3, 16'd2));
    send(32'hEEEE_0005);
    send(32'hFFFF_0006);
    settle();
    chk(reg_of(2, 3) == 32'hEEEE_0005, "R4 last in-range write", reg_of(2, 3), 32'hEEEE_0005);
    chk(reg_of(2, 0) == DEF, "R4 no wrap", reg_of(2, 0), DEF);
    chk(param_err_o == 3'b100, "R4 error only node2", W'(param_err_o), 32'h4);
    send(hdr(8'd3, 8'd0, 16'd1));
    send(32'h0BAD_0007);
    settle();
    chk(param_err_o[2] == 1'b1, "R4 error sticky", W'(param_err_o), 32'h4);
  endtask

  task automatic t_latency();
    logic [W-1:0] w;
    w = hdr(8'h77, 8'd0, 16'd0);
    send(w);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    repeat (NN - 1) @(negedge clk_i);
    chk(!tail_valid_o, "R6 not early", W'(tail_valid_o), '0);
    @(negedge clk_i);
    chk(tail_valid_o && tail_data_o == w, "R6 latency", tail_data_o, w);
    settle();
  endtask

  task automatic t_backpressure();
    logic [W-1:0] held;
    @(negedge clk_i);
    tail_ready_i = 1'b0;
    send(hdr(8'h77, 8'd0, 16'd4));
    for (int i = 1; i <= NN; i++) send(32'hB000_0000 + W'(i));
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk(!in_ready_o, "R7 ready low when full", W'(in_ready_o), '0);
    held = tail_data_o;
    repeat (3) @(negedge clk_i);
    chk(tail_valid_o && tail_data_o == held, "R7 tail held", tail_data_o, held);
    tail_ready_i = 1'b1;
    send(32'hB000_0004);
    settle();
  endtask

  task automatic t_order();
    chk(n_tail == n_sent, "R6 word count", W'(n_tail), W'(n_sent));
    for (int i = 0; i < n_sent && i < 256; i++)
      if (tail_log[i] !== sent_log[i])
        chk(1'b0, "R6 word order", tail_log[i], sent_log[i]);
    chk(1'b1, "R6 order scan", '0, '0);
  endtask

  task automatic t_end();
    send(32'hFF00_0000);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk(params_valid_o == '0, "R5 not yet", W'(params_valid_o), '0);
    repeat (NN + 2) @(negedge clk_i);
    chk(params_valid_o == '1, "R5 all valid", W'(params_valid_o), 32'h7);
    send(hdr(8'd1, 8'd0, 16'd1));
    send(32'h1234_5678);
    settle();
    chk(params_valid_o == '1, "R5 sticky", W'(params_valid_o), 32'h7);
    chk(reg_of(0, 0) == 32'h1234_5678, "R2 write after end", reg_of(0, 0), 32'h1234_5678);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_burst();
    t_zero_len();
    t_overwrite();
    t_out_of_range();
    t_latency();
    t_backpressure();
    t_end();
    t_order();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles >= 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule